// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block gathers a parameterised set of level-sensitive interrupt lines, 96 by default. For each source it keeps an enable, a pending and an active bit, together with an 8-bit priority and an 8-bit target field. Software reaches all of this state through a 32-bit single-cycle register port. Enable and pending state is changed only by writing ones into paired set and clear banks, so a read-modify-write is never needed.

Each cycle the block offers one CPU interface the best candidate. That is the source with the numerically lowest priority among those that are enabled, pending and not active. An acknowledge strobe naming that candidate moves it from pending to active. An end-of-interrupt strobe retires it. A line that stays high after retirement raises the source again.

Top module: `irq_dist_bank`

## Requirements
- R1: After reset every enable, pending, active, priority, target and control bit is 0, all register reads return 0 and no candidate is offered.
- R2: Offset 0x000 holds the forwarding enable in bit 0. It is written and read back there, and its other bits read 0.
- R3: The words at 0x100 + 4*w hold the enable of source n = 32*w + b in bit b. Writing 1 sets that enable and writing 0 leaves it unchanged. Reads at 0x100 + 4*w and at 0x180 + 4*w both return the enable state.
- R4: Writing 1 to bit b of word 0x180 + 4*w clears the enable of source 32*w + b. Writing 0 there leaves it unchanged.
- R5: Writing 1 to bit b of 0x200 + 4*w sets the pending bit of source 32*w + b, and writing 1 to the same bit of 0x280 + 4*w clears it. Both words read the pending state. Words at 0x300 + 4*w read the active bits, and writes there are ignored.
- R6: The priority of source n sits at word 0x400 + 4*(n/4), bits (n mod 4)*8 +: 8. The target of source n sits at word 0x800 + 4*(n/4) with the same byte packing. Both are written whole-word and read back unchanged.
- R7: The candidate is the enabled, pending, non-active source with the lowest priority value, with ties going to the lowest ID. No candidate is offered while the forwarding enable is 0 or no source qualifies, and in that case the ID and priority outputs read 0.
- R8: A high line on a source that is not active sets its pending bit at the next clock edge. A clear-pending write in the same cycle takes precedence for that edge.
- R9: An acknowledge whose ID equals the offered candidate clears that source's pending bit and sets its active bit on the same edge. An acknowledge with any other ID has no effect.
- R10: An end-of-interrupt clears the active bit of the named source. If that source's line is still high, it is pending again one clock later. While a source is active, its line does not set pending.
- R11: Words past the last source in any bank, and offsets that map to no bank, read 0. Writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | NUM_SRC | Level interrupt lines, one per source |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Byte offset of the register word |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, same cycle |
| fwd_valid_o | output | 1 | A candidate is offered |
| fwd_id_o | output | ID_W | ID of the offered candidate |
| fwd_prio_o | output | 8 | Priority of the offered candidate |
| ack_i | input | 1 | Acknowledge strobe |
| ack_id_i | input | ID_W | ID being acknowledged |
| eoi_i | input | 1 | End-of-interrupt strobe |
| eoi_id_i | input | ID_W | ID being retired |

## Verification
The bench builds the block with NUM_SRC = 40. This gives two bit-per-source words, the second only partly filled, and ten priority and target words. Every source can therefore be swept one at a time. The first word index past the end of each bank is also reachable, so the out-of-range behaviour can be checked. Distinct priorities drive a full acknowledge sequence through all 40 sources in priority order. Equal priorities then exercise the lowest-ID tie rule.

// File: rtl/irq_dist_pkg.sv
`timescale 1ns/1ps
package irq_dist_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned FLD_W  = 8;
  localparam int unsigned ADDR_W = 12;

  typedef enum logic [3:0] {
    RG_NONE, RG_CTRL, RG_SET_EN, RG_CLR_EN, RG_SET_PD, RG_CLR_PD,
    RG_ACT, RG_PRIO, RG_TGT
  } region_e;

  // bit banks live at 0x100..0x37F in 128-byte slices; byte banks at 0x400/0x800
  function automatic region_e region_of(input logic [ADDR_W-1:0] addr);
    if (addr[ADDR_W-1:2] == '0) return RG_CTRL;
    case (addr[11:7])
      5'h02: return RG_SET_EN;
      5'h03: return RG_CLR_EN;
      5'h04: return RG_SET_PD;
      5'h05: return RG_CLR_PD;
      5'h06: return RG_ACT;
      default: ;
    endcase
    if (addr[11:10] == 2'b01) return RG_PRIO;
    if (addr[11:10] == 2'b10) return RG_TGT;
    return RG_NONE;
  endfunction
endpackage

// File: rtl/irq_dist_decode.sv
`timescale 1ns/1ps
module irq_dist_decode
  import irq_dist_pkg::*;
#(
  parameter int unsigned NUM_SRC = 96
) (
  input  logic                           we_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [WORD_W-1:0]              wdata_i,
  output logic                           ctrl_we_o,
  output logic [NUM_SRC-1:0]             set_en_o,
  output logic [NUM_SRC-1:0]             clr_en_o,
  output logic [NUM_SRC-1:0]             set_pd_o,
  output logic [NUM_SRC-1:0]             clr_pd_o,
  output logic [NUM_SRC-1:0]             prio_we_o,
  output logic [NUM_SRC-1:0]             tgt_we_o,
  output logic [NUM_SRC-1:0][FLD_W-1:0]  field_o
);
  region_e    rg;
  logic [4:0] bit_idx;
  logic [7:0] byte_idx;

  assign rg        = region_of(addr_i);
  assign bit_idx   = addr_i[6:2];
  assign byte_idx  = addr_i[9:2];
  assign ctrl_we_o = we_i && (rg == RG_CTRL);

  for (genvar n = 0; n < int'(NUM_SRC); n++) begin : g_src
    localparam int unsigned BIT_WORD  = n / 32;
    localparam int unsigned BIT_POS   = n % 32;
    localparam int unsigned BYTE_WORD = n / 4;
    localparam int unsigned BYTE_POS  = (n % 4) * 8;
    logic bit_hit, byte_hit;
    assign bit_hit      = we_i && (bit_idx == 5'(BIT_WORD)) && wdata_i[BIT_POS];
    assign byte_hit     = we_i && (byte_idx == 8'(BYTE_WORD));
    assign set_en_o[n]  = bit_hit && (rg == RG_SET_EN);
    assign clr_en_o[n]  = bit_hit && (rg == RG_CLR_EN);
    assign set_pd_o[n]  = bit_hit && (rg == RG_SET_PD);
    assign clr_pd_o[n]  = bit_hit && (rg == RG_CLR_PD);
    assign prio_we_o[n] = byte_hit && (rg == RG_PRIO);
    assign tgt_we_o[n]  = byte_hit && (rg == RG_TGT);
    assign field_o[n]   = wdata_i[BYTE_POS +: FLD_W];
  end
endmodule

// File: rtl/irq_dist_src.sv
`timescale 1ns/1ps
module irq_dist_src
  import irq_dist_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_i,
  input  logic             set_en_i,
  input  logic             clr_en_i,
  input  logic             set_pd_i,
  input  logic             clr_pd_i,
  input  logic             prio_we_i,
  input  logic             tgt_we_i,
  input  logic [FLD_W-1:0] field_i,
  input  logic             ack_i,
  input  logic             eoi_i,
  output logic             en_o,
  output logic             pd_o,
  output logic             act_o,
  output logic [FLD_W-1:0] prio_o,
  output logic [FLD_W-1:0] tgt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= 1'b0;
      pd_o   <= 1'b0;
      act_o  <= 1'b0;
      prio_o <= '0;
      tgt_o  <= '0;
    end else begin
      if (set_en_i)      en_o <= 1'b1;
      else if (clr_en_i) en_o <= 1'b0;
      // acknowledge wins, then explicit clear, then any set source
      if (ack_i)                                   pd_o <= 1'b0;
      else if (clr_pd_i)                           pd_o <= 1'b0;
      else if (set_pd_i || (line_i && !act_o))     pd_o <= 1'b1;
      if (ack_i)      act_o <= 1'b1;
      else if (eoi_i) act_o <= 1'b0;
      if (prio_we_i) prio_o <= field_i;
      if (tgt_we_i)  tgt_o  <= field_i;
    end
  end
endmodule

// File: rtl/irq_dist_arb.sv
`timescale 1ns/1ps
module irq_dist_arb
  import irq_dist_pkg::*;
#(
  parameter int unsigned NUM_SRC = 96,
  parameter int unsigned ID_W    = 7
) (
  input  logic                          fwd_en_i,
  input  logic [NUM_SRC-1:0]            elig_i,
  input  logic [NUM_SRC-1:0][FLD_W-1:0] prio_i,
  output logic                          valid_o,
  output logic [ID_W-1:0]               id_o,
  output logic [FLD_W-1:0]              prio_o
);
  logic             found;
  logic [ID_W-1:0]  best_id;
  logic [FLD_W-1:0] best_p;

  // strict less-than keeps the earlier (lower) ID on equal priority
  always_comb begin
    found   = 1'b0;
    best_id = '0;
    best_p  = '1;
    for (int i = 0; i < int'(NUM_SRC); i++) begin
      if (elig_i[i] && (!found || prio_i[i] < best_p)) begin
        found   = 1'b1;
        best_id = ID_W'(i);
        best_p  = prio_i[i];
      end
    end
  end

  assign valid_o = found && fwd_en_i;
  assign id_o    = valid_o ? best_id : '0;
  assign prio_o  = valid_o ? best_p  : '0;
endmodule

// File: rtl/irq_dist_rdmux.sv
`timescale 1ns/1ps
module irq_dist_rdmux
  import irq_dist_pkg::*;
#(
  parameter int unsigned NUM_SRC = 96
) (
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic                          ctrl_en_i,
  input  logic [NUM_SRC-1:0]            en_i,
  input  logic [NUM_SRC-1:0]            pd_i,
  input  logic [NUM_SRC-1:0]            act_i,
  input  logic [NUM_SRC-1:0][FLD_W-1:0] prio_i,
  input  logic [NUM_SRC-1:0][FLD_W-1:0] tgt_i,
  output logic [WORD_W-1:0]             rdata_o
);
  region_e rg;
  int      bit_idx;
  int      byte_idx;

  assign rg       = region_of(addr_i);
  assign bit_idx  = int'(addr_i[6:2]);
  assign byte_idx = int'(addr_i[9:2]);

  always_comb begin
    rdata_o = '0;
    if (rg == RG_CTRL) rdata_o[0] = ctrl_en_i;
    for (int n = 0; n < int'(NUM_SRC); n++) begin
      if (bit_idx == n / 32) begin
        case (rg)
          RG_SET_EN, RG_CLR_EN: rdata_o[n % 32] = en_i[n];
          RG_SET_PD, RG_CLR_PD: rdata_o[n % 32] = pd_i[n];
          RG_ACT:               rdata_o[n % 32] = act_i[n];
          default: ;
        endcase
      end
      if (byte_idx == n / 4) begin
        if (rg == RG_PRIO) rdata_o[(n % 4) * 8 +: FLD_W] = prio_i[n];
        if (rg == RG_TGT)  rdata_o[(n % 4) * 8 +: FLD_W] = tgt_i[n];
      end
    end
  end
endmodule

// File: rtl/irq_dist_bank.sv
`timescale 1ns/1ps
module irq_dist_bank
  import irq_dist_pkg::*;
#(
  parameter int unsigned NUM_SRC = 96,
  localparam int unsigned ID_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic               reg_we_i,
  input  logic [11:0]        reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  output logic               fwd_valid_o,
  output logic [ID_W-1:0]    fwd_id_o,
  output logic [7:0]         fwd_prio_o,
  input  logic               ack_i,
  input  logic [ID_W-1:0]    ack_id_i,
  input  logic               eoi_i,
  input  logic [ID_W-1:0]    eoi_id_i
);
  logic                          ctrl_we, ctrl_en_q, ack_hit;
  logic [NUM_SRC-1:0]            set_en, clr_en, set_pd, clr_pd, prio_we, tgt_we;
  logic [NUM_SRC-1:0]            en_vec, pend_vec, act_vec, elig;
  logic [NUM_SRC-1:0][FLD_W-1:0] field, prio_vec, tgt_vec;

  irq_dist_decode #(.NUM_SRC(NUM_SRC)) u_dec (
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .ctrl_we_o(ctrl_we), .set_en_o(set_en), .clr_en_o(clr_en),
    .set_pd_o(set_pd), .clr_pd_o(clr_pd), .prio_we_o(prio_we),
    .tgt_we_o(tgt_we), .field_o(field)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_en_q <= 1'b0;
    else if (ctrl_we) ctrl_en_q <= reg_wdata_i[0];
  end

  assign ack_hit = ack_i && fwd_valid_o && (ack_id_i == fwd_id_o);

  for (genvar n = 0; n < int'(NUM_SRC); n++) begin : g_cell
    irq_dist_src u_src (
      .clk_i(clk_i), .rst_ni(rst_ni), .line_i(irq_i[n]),
      .set_en_i(set_en[n]), .clr_en_i(clr_en[n]),
      .set_pd_i(set_pd[n]), .clr_pd_i(clr_pd[n]),
      .prio_we_i(prio_we[n]), .tgt_we_i(tgt_we[n]), .field_i(field[n]),
      .ack_i(ack_hit && (fwd_id_o == ID_W'(n))),
      .eoi_i(eoi_i && (eoi_id_i == ID_W'(n))),
      .en_o(en_vec[n]), .pd_o(pend_vec[n]), .act_o(act_vec[n]),
      .prio_o(prio_vec[n]), .tgt_o(tgt_vec[n])
    );
  end

  assign elig = en_vec & pend_vec & ~act_vec;

  irq_dist_arb #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_arb (
    .fwd_en_i(ctrl_en_q), .elig_i(elig), .prio_i(prio_vec),
    .valid_o(fwd_valid_o), .id_o(fwd_id_o), .prio_o(fwd_prio_o)
  );

  irq_dist_rdmux #(.NUM_SRC(NUM_SRC)) u_rd (
    .addr_i(reg_addr_i), .ctrl_en_i(ctrl_en_q), .en_i(en_vec),
    .pd_i(pend_vec), .act_i(act_vec), .prio_i(prio_vec), .tgt_i(tgt_vec),
    .rdata_o(reg_rdata_o)
  );
endmodule

// File: rtl/irq_dist_chk.sv
`timescale 1ns/1ps
module irq_dist_chk #(
  parameter int unsigned NUM_SRC = 96,
  parameter int unsigned ID_W    = 7
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ack_i,
  input logic [ID_W-1:0]    ack_id_i,
  input logic               eoi_i,
  input logic [ID_W-1:0]    eoi_id_i,
  input logic               fwd_valid_o,
  input logic [ID_W-1:0]    fwd_id_o,
  input logic               ctrl_en_q,
  input logic [NUM_SRC-1:0] en_vec,
  input logic [NUM_SRC-1:0] pend_vec,
  input logic [NUM_SRC-1:0] act_vec
);
  a_r7_fwd_needs_ctrl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_valid_o |-> ctrl_en_q);

  a_r7_fwd_eligible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_valid_o |-> (en_vec[fwd_id_o] && pend_vec[fwd_id_o] && !act_vec[fwd_id_o]));

  a_r9_ack_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && fwd_valid_o && ack_id_i == fwd_id_o)
    |=> (act_vec[$past(ack_id_i)] && !pend_vec[$past(ack_id_i)]));

  a_r10_eoi_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && (32'(eoi_id_i) < NUM_SRC) &&
     !(ack_i && fwd_valid_o && ack_id_i == fwd_id_o && ack_id_i == eoi_id_i))
    |=> !act_vec[$past(eoi_id_i)]);
endmodule

bind irq_dist_bank irq_dist_chk #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ack_i(ack_i), .ack_id_i(ack_id_i),
  .eoi_i(eoi_i), .eoi_id_i(eoi_id_i), .fwd_valid_o(fwd_valid_o),
  .fwd_id_o(fwd_id_o), .ctrl_en_q(ctrl_en_q), .en_vec(en_vec),
  .pend_vec(pend_vec), .act_vec(act_vec)
);

// File: tb/irq_dist_bank_bench.sv
`timescale 1ns/1ps
module irq_dist_bank_bench;
  localparam int N    = 40;
  localparam int ID_W = 6;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic [N-1:0]    irq = '0;
  logic            we = 1'b0;
  logic [11:0]     addr = '0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic            fv;
  logic [ID_W-1:0] fid;
  logic [7:0]      fprio;
  logic            ack = 1'b0, eoi = 1'b0;
  logic [ID_W-1:0] ack_id = '0, eoi_id = '0;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  logic       m_en [N];
  logic       m_pd [N];
  logic       m_ac [N];
  logic [7:0] m_pr [N];
  logic       m_ctrl;

  always #2.5 clk = ~clk;

  irq_dist_bank #(.NUM_SRC(N)) u_irq_dist_bank (
    .clk_i(clk), .rst_ni(rst_ni), .irq_i(irq), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .fwd_valid_o(fv), .fwd_id_o(fid), .fwd_prio_o(fprio),
    .ack_i(ack), .ack_id_i(ack_id), .eoi_i(eoi), .eoi_id_i(eoi_id)
  );

  function automatic logic [7:0] pfn(int n); return 8'((n * 37 + 11) & 255); endfunction
  function automatic logic [7:0] tfn(int n); return 8'((n * 91 + 5) & 255); endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1; we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic do_ack(input int id);
    @(negedge clk); ack = 1'b1; ack_id = ID_W'(id);
    @(posedge clk); #1; ack = 1'b0;
  endtask

  task automatic do_eoi(input int id);
    @(negedge clk); eoi = 1'b1; eoi_id = ID_W'(id);
    @(posedge clk); #1; eoi = 1'b0;
  endtask

  function automatic logic [31:0] bits_of(int kind, int w);
    logic [31:0] r = '0;
    for (int b = 0; b < 32; b++) begin
      int n = w * 32 + b;
      if (n < N) r[b] = (kind == 0) ? m_en[n] : (kind == 1) ? m_pd[n] : m_ac[n];
    end
    return r;
  endfunction

  task automatic exp_cand(output logic v, output int id, output logic [7:0] p);
    v = 1'b0; id = 0; p = 8'hFF;
    for (int n = 0; n < N; n++)
      if (m_en[n] && m_pd[n] && !m_ac[n] && (!v || m_pr[n] < p)) begin
        v = 1'b1; id = n; p = m_pr[n];
      end
    if (!m_ctrl) v = 1'b0;
    if (!v) begin id = 0; p = 8'h00; end
  endtask

  task automatic chk_cand(input string tag);
    logic v; int id; logic [7:0] p;
    exp_cand(v, id, p);
    @(negedge clk); #1;
    chk({tag, " valid"}, 32'(fv), 32'(v));
    chk({tag, " id"}, 32'(fid), 32'(id));
    chk({tag, " prio"}, 32'(fprio), 32'(p));
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    for (int n = 0; n < N; n++) begin m_en[n] = 0; m_pd[n] = 0; m_ac[n] = 0; m_pr[n] = 0; end
    m_ctrl = 0;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;

    // R1 reset state
    chk_cand("R1 reset candidate");
    foreach (d[i]) ;
    rd(12'h000, d); chk("R1 ctrl", d, 0);
    rd(12'h100, d); chk("R1 enable", d, 0);
    rd(12'h204, d); chk("R1 pending", d, 0);
    rd(12'h300, d); chk("R1 active", d, 0);
    rd(12'h400, d); chk("R1 prio", d, 0);
    rd(12'h824, d); chk("R1 target", d, 0);

    // R2 control register
    wr(12'h000, 32'hFFFF_FFFF); rd(12'h000, d); chk("R2 ctrl set", d, 1);
    wr(12'h000, 32'h0000_0000); rd(12'h000, d); chk("R2 ctrl clear", d, 0);

    // R3 set-enable sweep, one source at a time
    for (int n = 0; n < N; n++) begin
      wr(12'(12'h100 + 4 * (n / 32)), 32'(1) << (n % 32));
      m_en[n] = 1;
      rd(12'(12'h100 + 4 * (n / 32)), d); chk($sformatf("R3 set-enable src %0d", n), d, bits_of(0, n / 32));
    end
    wr(12'h100, 32'h0); wr(12'h104, 32'h0);
    rd(12'h180, d); chk("R3 zero write, alias word0", d, bits_of(0, 0));
    rd(12'h184, d); chk("R3 zero write, alias word1", d, bits_of(0, 1));

    // R4 clear even sources
    for (int n = 0; n < N; n += 2) begin
      wr(12'(12'h180 + 4 * (n / 32)), 32'(1) << (n % 32));
      m_en[n] = 0;
    end
    wr(12'h180, 32'h0);
    rd(12'h100, d); chk("R4 clear-enable word0", d, bits_of(0, 0));
    rd(12'h104, d); chk("R4 clear-enable word1", d, bits_of(0, 1));

    // R6 priority and target packing
    for (int w = 0; w < N / 4; w++) begin
      wr(12'(12'h400 + 4 * w), {pfn(4*w+3), pfn(4*w+2), pfn(4*w+1), pfn(4*w)});
      wr(12'(12'h800 + 4 * w), {tfn(4*w+3), tfn(4*w+2), tfn(4*w+1), tfn(4*w)});
      for (int k = 0; k < 4; k++) m_pr[4*w+k] = pfn(4*w+k);
    end
    for (int w = 0; w < N / 4; w++) begin
      rd(12'(12'h400 + 4 * w), d);
      chk($sformatf("R6 prio word %0d", w), d, {pfn(4*w+3), pfn(4*w+2), pfn(4*w+1), pfn(4*w)});
      rd(12'(12'h800 + 4 * w), d);
      chk($sformatf("R6 target word %0d", w), d, {tfn(4*w+3), tfn(4*w+2), tfn(4*w+1), tfn(4*w)});
    end

    // R11 unmapped and out-of-range words
    wr(12'h108, 32'hFFFF_FFFF); rd(12'h108, d); chk("R11 enable word past end", d, 0);
    rd(12'h100, d); chk("R11 enable word0 untouched", d, bits_of(0, 0));
    wr(12'h428, 32'hFFFF_FFFF); rd(12'h428, d); chk("R11 prio word past end", d, 0);
    rd(12'h424, d); chk("R11 prio last word untouched", d, {pfn(39), pfn(38), pfn(37), pfn(36)});
    wr(12'hF00, 32'hFFFF_FFFF); rd(12'hF00, d); chk("R11 unmapped offset", d, 0);
    rd(12'h000, d); chk("R11 ctrl untouched", d, 0);

    // R5 pending and active banks
    wr(12'h100, 32'hFFFF_FFFF); wr(12'h104, 32'hFFFF_FFFF);
    for (int n = 0; n < N; n++) m_en[n] = 1;
    wr(12'h200, 32'hFFFF_FFFF); wr(12'h204, 32'hFFFF_FFFF);
    for (int n = 0; n < N; n++) m_pd[n] = 1;
    rd(12'h284, d); chk("R5 pending word1", d, 32'h0000_00FF);
    wr(12'h300, 32'hFFFF_FFFF); rd(12'h300, d); chk("R5 active read-only", d, 0);
    chk_cand("R7 ctrl off no candidate");

    // R7/R9 full acknowledge sequence in priority order
    wr(12'h000, 32'h1); m_ctrl = 1;
    chk_cand("R7 first candidate");
    begin
      logic v; int id; logic [7:0] p;
      exp_cand(v, id, p);
      do_ack((id + 1) % N);
      chk_cand("R9 mismatched ack ignored");
      rd(12'h300, d); chk("R9 mismatched ack active", d, 0);
    end
    for (int k = 0; k <= N; k++) begin
      logic v; int id; logic [7:0] p;
      exp_cand(v, id, p);
      chk_cand($sformatf("R7 order step %0d", k));
      if (!v) break;
      do_ack(id); m_pd[id] = 0; m_ac[id] = 1;
    end
    rd(12'h300, d); chk("R9 all active word0", d, 32'hFFFF_FFFF);
    rd(12'h304, d); chk("R9 all active word1", d, 32'h0000_00FF);
    rd(12'h200, d); chk("R9 pending cleared", d, 0);

    // R10 retire every source
    for (int n = 0; n < N; n++) begin do_eoi(n); m_ac[n] = 0; end
    rd(12'h300, d); chk("R10 active cleared word0", d, 0);
    rd(12'h304, d); chk("R10 active cleared word1", d, 0);

    // R7 ties go to the lowest ID
    for (int w = 0; w < N / 4; w++) wr(12'(12'h400 + 4 * w), 32'h4040_4040);
    for (int n = 0; n < N; n++) m_pr[n] = 8'h40;
    wr(12'h200, 32'hFFFF_FFFF); wr(12'h204, 32'hFFFF_FFFF);
    for (int n = 0; n < N; n++) m_pd[n] = 1;
    chk_cand("R7 tie lowest id");
    wr(12'h180, 32'h1); m_en[0] = 0;
    chk_cand("R4 disabled source skipped");
    wr(12'h410, 32'h4040_1040); m_pr[17] = 8'h10;
    chk_cand("R7 lower value wins");
    wr(12'h000, 32'h0); m_ctrl = 0;
    chk_cand("R7 ctrl cleared");
    wr(12'h280, 32'hFFFF_FFFF); wr(12'h284, 32'hFFFF_FFFF);
    for (int n = 0; n < N; n++) m_pd[n] = 0;
    rd(12'h200, d); chk("R5 clear-pending", d, 0);
    wr(12'h000, 32'h1); m_ctrl = 1;

    // R8/R10 level line behaviour on source 3
    @(negedge clk); irq[3] = 1'b1;
    rd(12'h200, d); chk("R8 line sets pending", d, 32'h8);
    chk("R8 line candidate", 32'(fid), 3);
    wr(12'h280, 32'h8);
    rd(12'h200, d); chk("R8 clear wins same edge", d, 0);
    rd(12'h200, d); chk("R8 line re-pends", d, 32'h8);
    do_ack(3);
    rd(12'h300, d); chk("R9 ack sets active", d, 32'h8);
    rd(12'h200, d); chk("R10 line ignored while active", d, 0);
    do_eoi(3);
    rd(12'h300, d); chk("R10 eoi clears active", d, 0);
    chk("R10 no candidate right after eoi", 32'(fv), 0);
    rd(12'h200, d); chk("R10 line re-pends after eoi", d, 32'h8);
    chk("R10 candidate after eoi", 32'(fid), 3);
    chk("R10 candidate valid after eoi", 32'(fv), 1);

    done = 1'b1;
    finish_run();
  end
endmodule